// File: doc/BRIEF.md
# Codec Serial Receive Controller

This block takes the serial data stream coming back from an audio codec and turns it into 32-bit words for the host. A rising-edge strobe of the serial bit clock qualifies every input bit. A frame-sync marker starts a word. The next 32 qualified bits are shifted in most-significant bit first. When the last of those bits arrives, the shift register's contents move into a holding buffer. On the following clock the buffer is pushed into an eight-entry receive queue, which is split into two blocks of four.

The host drains the queue through a read port that always shows the oldest word. The block can signal the host in one of two ways. In programmed-I/O mode, an interrupt line is driven from three sticky event flags and their enable mask. In DMA mode, an active-low request line has hysteresis: it asserts when the queue is close to full and releases once the queue is nearly empty.

Top module: `codec_rx_ctrl`

## Requirements
- R1: After reset, `stat` is 000, `irq` is 0, `dreq_n` is 1, `rd_data` is 0 and the queue is empty.
- R2: A bit strobe with `fsync` high arms capture. The next 32 bit strobes shift `sdin` in MSB first, and the completed word enters the queue. Bit strobes while capture is not armed are ignored.
- R3: The queue holds 8 words. `rd_data` shows the oldest word without being requested, and a one-cycle `rd_en` removes it. Words leave in arrival order.
- R4: When a captured word arrives while the queue holds 8 words, that word is discarded, the contents are unchanged, and `stat[2]` (overrun) is set.
- R5: An `rd_en` on an empty queue returns `rd_data` = 0, changes nothing, and sets `stat[1]` (underrun).
- R6: `stat[0]` (block done) is set when a write fills the last entry of either four-entry block, that is, queue slot 3 or slot 7 counted from reset.
- R7: Status bits are sticky. A cycle with `clr_stb` high clears exactly the bits that are 1 in `clr_mask`. A bit that is being set in that same cycle stays set.
- R8: When `dma_mode` is 0, `irq` is the OR of `stat & irq_en`. When `dma_mode` is 1, `irq` is 0.
- R9: When `dma_mode` is 1, `dreq_n` goes low once the queue holds 6 or more words. It stays low until the queue holds 1 word or fewer, then goes high. When `dma_mode` is 0, `dreq_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_stb | input | 1 | One-cycle strobe marking a rising serial bit-clock edge |
| fsync | input | 1 | Frame-sync marker, sampled on `bit_stb` |
| sdin | input | 1 | Serial data, sampled on `bit_stb` |
| rd_en | input | 1 | Pop the oldest queued word |
| rd_data | output | 32 | Oldest queued word, 0 when empty |
| clr_stb | input | 1 | Apply the write-1-to-clear mask to the status bits |
| clr_mask | input | 3 | Status bits to clear |
| irq_en | input | 3 | Interrupt enable per status bit |
| dma_mode | input | 1 | 1 selects DMA signalling, 0 selects interrupt signalling |
| stat | output | 3 | {overrun, underrun, block done} |
| irq | output | 1 | Interrupt request |
| dreq_n | output | 1 | Active-low DMA request |

## Verification
Frames carrying distinct, asymmetric words are popped through a scoreboard. This exposes a reversed bit order, an off-by-one bit count and misordered queue slots. Strobes sent without a preceding frame sync show whether stray bits get captured. Filling the queue one word at a time checks the exact occupancy at which block done, overrun and the DMA request edges occur. Draining the queue checks both the release threshold of the request and the zero returned by an empty read.

// File: rtl/codec_rx_pkg.sv
package codec_rx_pkg;
    localparam int WORD_W    = 32;
    localparam int BLK_DEPTH = 4;
    localparam int NUM_BLK   = 2;
    localparam int HI_MARK   = 6;
    localparam int LO_MARK   = 1;

    // bit 2 overrun, bit 1 underrun, bit 0 block done
    typedef struct packed {
        logic ovr;
        logic unr;
        logic done;
    } rx_stat_t;

    // Wrap a slot pointer inside a queue of the given depth.
    function automatic int unsigned ptr_next(input int unsigned p, input int unsigned depth);
        return (p == depth - 1) ? 0 : p + 1;
    endfunction

    // True when a slot index is the final entry of its block.
    function automatic logic blk_tail(input int unsigned p, input int unsigned blk);
        return (p % blk) == (blk - 1);
    endfunction
endpackage

// File: rtl/rx_deser.sv
module rx_deser #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         bit_stb,
    input  logic         fsync,
    input  logic         sdin,
    output logic         wr_req,
    output logic [W-1:0] wr_word
);
    localparam int CW = $clog2(W + 1);

    logic [W-1:0]  shreg;
    logic [W-1:0]  hold;
    logic          hold_full;
    logic          armed;
    logic [CW-1:0] bitcnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg     <= '0;
            hold      <= '0;
            hold_full <= 1'b0;
            armed     <= 1'b0;
            bitcnt    <= '0;
        end else begin
            if (hold_full)
                hold_full <= 1'b0;
            if (bit_stb) begin
                if (fsync) begin
                    armed  <= 1'b1;
                    bitcnt <= '0;
                end else if (armed) begin
                    shreg  <= {shreg[W-2:0], sdin};
                    bitcnt <= bitcnt + 1'b1;
                    if (bitcnt == CW'(W - 1)) begin
                        hold      <= {shreg[W-2:0], sdin};
                        hold_full <= 1'b1;
                        armed     <= 1'b0;
                    end
                end
            end
        end
    end

    assign wr_req  = hold_full;
    assign wr_word = hold;

    p_bitcnt_range_r2: assert property (@(posedge clk) disable iff (rst)
        armed |-> (bitcnt < CW'(W)));
    p_single_push_r2: assert property (@(posedge clk) disable iff (rst)
        hold_full |=> !hold_full);
endmodule

// File: rtl/rx_fifo.sv
module rx_fifo
    import codec_rx_pkg::*;
#(
    parameter int W       = 32,
    parameter int BLK     = 4,
    parameter int NBLK    = 2,
    localparam int DEPTH  = BLK * NBLK,
    localparam int PTR_W  = $clog2(DEPTH),
    localparam int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_req,
    input  logic [W-1:0]     wr_word,
    input  logic             rd_en,
    output logic [W-1:0]     rd_data,
    output logic [CNT_W-1:0] count,
    output logic             ev_done,
    output logic             ev_ovr,
    output logic             ev_unr
);
    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic             full;
    logic             empty;
    logic             do_wr;
    logic             do_rd;

    assign full    = (count == CNT_W'(DEPTH));
    assign empty   = (count == '0);
    assign do_wr   = wr_req && !full;
    assign do_rd   = rd_en && !empty;
    assign ev_ovr  = wr_req && full;
    assign ev_unr  = rd_en && empty;
    assign ev_done = do_wr && blk_tail(int'(wr_ptr), BLK);
    assign rd_data = empty ? '0 : mem[rd_ptr];

    for (genvar s = 0; s < DEPTH; s++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)
                mem[s] <= '0;
            else if (do_wr && wr_ptr == PTR_W'(s))
                mem[s] <= wr_word;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_wr)
                wr_ptr <= PTR_W'(ptr_next(int'(wr_ptr), DEPTH));
            if (do_rd)
                rd_ptr <= PTR_W'(ptr_next(int'(rd_ptr), DEPTH));
            case ({do_wr, do_rd})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    p_count_bound_r3: assert property (@(posedge clk) disable iff (rst)
        count <= CNT_W'(DEPTH));
    p_ovr_drop_r4: assert property (@(posedge clk) disable iff (rst)
        (wr_req && full && !rd_en) |=> count == CNT_W'(DEPTH));
    p_unr_nochange_r5: assert property (@(posedge clk) disable iff (rst)
        (rd_en && empty && !wr_req) |=> count == '0);
endmodule

// File: rtl/rx_status.sv
module rx_status
    import codec_rx_pkg::*;
#(
    parameter int CNT_W = 4,
    parameter int HI    = 6,
    parameter int LO    = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ev_done,
    input  logic             ev_unr,
    input  logic             ev_ovr,
    input  logic             clr_stb,
    input  logic [2:0]       clr_mask,
    input  logic [2:0]       irq_en,
    input  logic             dma_mode,
    input  logic [CNT_W-1:0] count,
    output rx_stat_t         stat,
    output logic             irq,
    output logic             dreq_n
);
    rx_stat_t set_v;
    logic [2:0] clr_v;
    logic       req_q;

    assign set_v = '{ovr: ev_ovr, unr: ev_unr, done: ev_done};
    assign clr_v = clr_stb ? clr_mask : 3'b000;

    always_ff @(posedge clk) begin
        if (rst) begin
            stat  <= '0;
            req_q <= 1'b0;
        end else begin
            stat <= (stat & ~clr_v) | set_v;
            if (count >= CNT_W'(HI))
                req_q <= 1'b1;
            else if (count <= CNT_W'(LO))
                req_q <= 1'b0;
        end
    end

    assign irq    = !dma_mode && |(stat & irq_en);
    assign dreq_n = !(dma_mode && req_q);

    p_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        (stat.done && !(clr_stb && clr_mask[0])) |=> stat.done);
    p_dreq_on_r9: assert property (@(posedge clk) disable iff (rst)
        (dma_mode && count >= CNT_W'(HI)) |=> (!dreq_n || !dma_mode));
    p_dreq_off_r9: assert property (@(posedge clk) disable iff (rst)
        (count <= CNT_W'(LO)) |=> dreq_n);
endmodule

// File: rtl/codec_rx_ctrl.sv
module codec_rx_ctrl
    import codec_rx_pkg::*;
#(
    parameter int W         = WORD_W,
    parameter int BLK       = BLK_DEPTH,
    parameter int NBLK      = NUM_BLK,
    parameter int HI        = HI_MARK,
    parameter int LO        = LO_MARK,
    localparam int CNT_W    = $clog2(BLK * NBLK + 1)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         bit_stb,
    input  logic         fsync,
    input  logic         sdin,
    input  logic         rd_en,
    output logic [W-1:0] rd_data,
    input  logic         clr_stb,
    input  logic [2:0]   clr_mask,
    input  logic [2:0]   irq_en,
    input  logic         dma_mode,
    output logic [2:0]   stat,
    output logic         irq,
    output logic         dreq_n
);
    logic             wr_req;
    logic [W-1:0]     wr_word;
    logic [CNT_W-1:0] count;
    logic             ev_done;
    logic             ev_ovr;
    logic             ev_unr;
    rx_stat_t         stat_s;

    rx_deser #(.W(W)) u_deser (
        .clk     (clk),
        .rst     (rst),
        .bit_stb (bit_stb),
        .fsync   (fsync),
        .sdin    (sdin),
        .wr_req  (wr_req),
        .wr_word (wr_word)
    );

    rx_fifo #(.W(W), .BLK(BLK), .NBLK(NBLK)) u_fifo (
        .clk     (clk),
        .rst     (rst),
        .wr_req  (wr_req),
        .wr_word (wr_word),
        .rd_en   (rd_en),
        .rd_data (rd_data),
        .count   (count),
        .ev_done (ev_done),
        .ev_ovr  (ev_ovr),
        .ev_unr  (ev_unr)
    );

    rx_status #(.CNT_W(CNT_W), .HI(HI), .LO(LO)) u_status (
        .clk      (clk),
        .rst      (rst),
        .ev_done  (ev_done),
        .ev_unr   (ev_unr),
        .ev_ovr   (ev_ovr),
        .clr_stb  (clr_stb),
        .clr_mask (clr_mask),
        .irq_en   (irq_en),
        .dma_mode (dma_mode),
        .count    (count),
        .stat     (stat_s),
        .irq      (irq),
        .dreq_n   (dreq_n)
    );

    assign stat = stat_s;
endmodule

// File: tb/codec_rx_ctrl_tb.sv
module codec_rx_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bit_stb = 1'b0;
    logic        fsync = 1'b0;
    logic        sdin = 1'b0;
    logic        rd_en = 1'b0;
    logic [31:0] rd_data;
    logic        clr_stb = 1'b0;
    logic [2:0]  clr_mask = 3'b000;
    logic [2:0]  irq_en = 3'b000;
    logic        dma_mode = 1'b0;
    logic [2:0]  stat;
    logic        irq;
    logic        dreq_n;

    int checks = 0;
    int errors = 0;
    logic [31:0] exp_q [$];

    always #(CLK_PERIOD / 2) clk = ~clk;

    codec_rx_ctrl dut_i (
        .clk(clk), .rst(rst), .bit_stb(bit_stb), .fsync(fsync), .sdin(sdin),
        .rd_en(rd_en), .rd_data(rd_data), .clr_stb(clr_stb), .clr_mask(clr_mask),
        .irq_en(irq_en), .dma_mode(dma_mode), .stat(stat), .irq(irq), .dreq_n(dreq_n)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic strobe(input logic fs, input logic d);
        @(negedge clk);
        bit_stb = 1'b1; fsync = fs; sdin = d;
        @(negedge clk);
        bit_stb = 1'b0; fsync = 1'b0; sdin = 1'b0;
    endtask

    // Driver: sends one frame and records the word it expects to be queued.
    task automatic send_frame(input logic [31:0] w, input bit expect_it);
        strobe(1'b1, 1'b0);
        for (int i = 31; i >= 0; i--) strobe(1'b0, w[i]);
        if (expect_it) exp_q.push_back(w);
        repeat (3) @(negedge clk);
    endtask

    // Monitor: compares the head word with the scoreboard, then pops it.
    task automatic pop_check(input string req);
        logic [31:0] e;
        e = (exp_q.size() > 0) ? exp_q.pop_front() : 32'h0;
        chk(req, rd_data, e);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        @(negedge clk);
    endtask

    task automatic clear(input logic [2:0] m);
        @(negedge clk);
        clr_stb = 1'b1; clr_mask = m;
        @(negedge clk);
        clr_stb = 1'b0; clr_mask = 3'b000;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 stat", {29'd0, stat}, 32'd0);
        chk("R1 irq", {31'd0, irq}, 32'd0);
        chk("R1 dreq_n", {31'd0, dreq_n}, 32'd1);
        chk("R1 rd_data", rd_data, 32'd0);

        // R2 stray strobes without frame sync are not captured
        for (int i = 0; i < 10; i++) strobe(1'b0, 1'b1);
        chk("R2 stray bits", rd_data, 32'd0);

        // R6: slots 0..2 leave block done clear, slot 3 sets it
        send_frame(32'h8000_0001, 1'b1);
        send_frame(32'h1234_5678, 1'b1);
        send_frame(32'hC0FF_EE03, 1'b1);
        chk("R6 not yet done", {29'd0, stat}, 32'd0);
        send_frame(32'h0F0F_A5A5, 1'b1);
        chk("R6 block done", {29'd0, stat}, 32'd1);

        // R8 interrupt masking and DMA gating
        chk("R8 masked", {31'd0, irq}, 32'd0);
        irq_en = 3'b001;
        @(negedge clk);
        chk("R8 enabled", {31'd0, irq}, 32'd1);
        dma_mode = 1'b1;
        @(negedge clk);
        chk("R8 dma gates irq", {31'd0, irq}, 32'd0);
        dma_mode = 1'b0;

        // R7 sticky, then write-1-to-clear
        repeat (5) @(negedge clk);
        chk("R7 sticky", {29'd0, stat}, 32'd1);
        clear(3'b110);
        chk("R7 unmasked bit kept", {29'd0, stat}, 32'd1);
        clear(3'b001);
        chk("R7 cleared", {29'd0, stat}, 32'd0);

        // R2 R3 order and bit order via scoreboard
        for (int i = 0; i < 4; i++) pop_check("R3 pop order R2");

        // R5 underrun on empty read
        chk("R5 empty data", rd_data, 32'd0);
        rd_en = 1'b1; @(negedge clk); rd_en = 1'b0; @(negedge clk);
        chk("R5 underrun flag", {29'd0, stat}, 32'd2);
        clear(3'b111);

        // R4 overrun: fill 8, ninth dropped
        for (int i = 0; i < 8; i++) send_frame(32'hA000_0000 + 32'(i * 32'h0101_0011), 1'b1);
        chk("R4 no overrun at 8", {31'd0, stat[2]}, 32'd0);
        send_frame(32'hDEAD_BEEF, 1'b0);
        chk("R4 overrun flag", {31'd0, stat[2]}, 32'd1);
        for (int i = 0; i < 8; i++) pop_check("R4 R3 contents kept");
        chk("R4 ninth dropped", rd_data, 32'd0);
        clear(3'b111);

        // R9 DMA request hysteresis
        dma_mode = 1'b1;
        for (int i = 0; i < 5; i++) send_frame(32'h5000_0000 | 32'(i), 1'b1);
        chk("R9 5 words no req", {31'd0, dreq_n}, 32'd1);
        send_frame(32'h5000_0005, 1'b1);
        chk("R9 6 words req", {31'd0, dreq_n}, 32'd0);
        dma_mode = 1'b0;
        @(negedge clk);
        chk("R9 pio no req", {31'd0, dreq_n}, 32'd1);
        dma_mode = 1'b1;
        for (int i = 0; i < 4; i++) pop_check("R9 R3 drain");
        @(negedge clk);
        chk("R9 2 words held", {31'd0, dreq_n}, 32'd0);
        pop_check("R9 R3 drain");
        @(negedge clk);
        chk("R9 1 word release", {31'd0, dreq_n}, 32'd1);
        pop_check("R9 R3 last");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule